// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

The block decides which interrupt a CPU core should serve next. It has one external request line and five peripheral request lines: an ADC, three PWM/timer units and a UART. It uses seven priority levels. Level 0 is the highest and always belongs to the external line. Levels 1 to 5 are slots that software fills with a 3-bit peripheral code. Level 6 means the main program is running.

Software programs the slots by writing two byte-wide configuration registers. A request at a numerically lower level than the one executing preempts it at once. The block marks each taken level as in service, so nested handlers unwind in order. Each handler ends with a one-cycle return pulse. On that pulse the innermost in-service level is cleared and the preempted level becomes current again.

Request pulses are held as pending until they are taken, so short requests are not lost while a more urgent handler runs.

Top module: `prio_intc`

## Requirements
- R1: After reset `cur_level` is 6 and `take` is 0. The slot field holds codes 0,1,2,3,4 in levels 1..5 respectively, so a request on `per_req[3]` alone is taken at level 4.
- R2: Writing with `cfg_sel`=0 loads field bits 7:0 from `cfg_wdata`. Writing with `cfg_sel`=1 loads field bits 14:8 from `cfg_wdata[6:0]`, and `cfg_wdata[7]` is ignored. Level k (1..5) reads its code from field bits 3k-1:3k-3. For example, 0xC1 then 0xA8 maps levels 1..5 to codes 1,0,3,4,2.
- R3: `ext_req` always maps to level 0, and a take at level 0 reports `take_code` 3'b111.
- R4: `per_req[c]` is the request of the peripheral with code c: ADC 0, timer0 1, timer1 2, timer2 3, UART 4. A take at levels 1..5 reports the slot's code on `take_code`.
- R5: A request whose level is below `cur_level` is taken at the next clock edge. In the following cycle `take` is 1, and `take_level` and `cur_level` both equal the new level.
- R6: A request at a level equal to or above `cur_level` is not taken while that level is executing.
- R7: A `reti` pulse clears the innermost in-service level, and `cur_level` returns to the level it preempted (6 when none). No take happens on that edge. Waiting requests are considered again from the next edge.
- R8: A request pulse stays pending until it is taken, even if the line drops first.
- R9: If two slots hold the same code, only the lower-numbered slot ever fires for that peripheral.
- R10: A slot holding code 5, 6 or 7 never fires.
- R11: When several levels are requested in the same cycle, the lowest-numbered level wins.
- R12: `reti` while `cur_level` is 6 leaves `cur_level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the low slot register, 1 the high |
| cfg_wdata | input | 8 | Configuration write data |
| ext_req | input | 1 | External interrupt request (level 0) |
| per_req | input | 5 | Peripheral requests, bit index = peripheral code |
| reti | input | 1 | Return-from-interrupt pulse |
| cur_level | output | 3 | Level now executing (6 = main program) |
| take | output | 1 | One-cycle strobe: an interrupt was taken |
| take_level | output | 3 | Level of the taken interrupt |
| take_code | output | 3 | Peripheral code taken, 3'b111 for external |

## Verification
The assertions assume that `reti` is pulsed only by a handler that is actually running, and that every code written to a slot is either a real peripheral code or deliberately unused. Under that assumption the in-service set only ever grows by a take and shrinks by a return. The random stimulus, however, also issues returns while the main program runs, and writes arbitrary slot bytes, duplicates included. The controller must tolerate both. It does so because a return with nothing in service is a no-op, and because a slot's code is checked against the range of real codes before it can fire.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int CODE_W   = 3;
  localparam int NUM_SLOT = 5;
  localparam int NUM_PER  = 5;
  localparam int LVL_W    = 3;
endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs #(
  parameter int CW    = 3,
  parameter int NSLOT = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic                  sel,
  input  logic [7:0]            wdata,
  output logic [NSLOT*CW-1:0]   field
);
  localparam int FW = NSLOT * CW;
  localparam int HW = FW - 8;

  function automatic logic [FW-1:0] default_map();
    logic [FW-1:0] v;
    v = '0;
    for (int k = 0; k < NSLOT; k++) v[k*CW +: CW] = CW'(k);
    return v;
  endfunction

  localparam logic [FW-1:0] RST_MAP = default_map();

  logic [7:0]    lo_q;
  logic [HW-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= RST_MAP[7:0];
      hi_q <= RST_MAP[FW-1:8];
    end else if (we) begin
      if (sel) hi_q <= wdata[HW-1:0];
      else     lo_q <= wdata;
    end
  end

  assign field = {hi_q, lo_q};

  assert_hi_write_R2: assert property (@(posedge clk) disable iff (rst)
    (we && sel) |=> (field[FW-1:8] == $past(wdata[HW-1:0])));
  assert_lo_keep_R2: assert property (@(posedge clk) disable iff (rst)
    (we && sel) |=> $stable(field[7:0]));
endmodule

// File: rtl/intc_req_map.sv
module intc_req_map #(
  parameter int CW    = 3,
  parameter int NSLOT = 5,
  parameter int NPER  = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ext_req,
  input  logic [NPER-1:0]            per_req,
  input  logic [NSLOT*CW-1:0]        field,
  input  logic                       clr_ext,
  input  logic [NPER-1:0]            clr_per,
  output logic [NSLOT:0]             lvl_req,
  output logic [NSLOT:0][CW-1:0]     lvl_code
);
  logic [NPER-1:0] pend_q, eff_pend;
  logic            ext_q, eff_ext;
  logic [CW-1:0]   code, other;
  logic            dup, hit;

  always_comb begin
    eff_pend    = pend_q | per_req;
    eff_ext     = ext_q | ext_req;
    lvl_req     = '0;
    lvl_code    = '0;
    code        = '0;
    other       = '0;
    dup         = 1'b0;
    hit         = 1'b0;
    lvl_req[0]  = eff_ext;
    lvl_code[0] = '1;
    for (int k = 1; k <= NSLOT; k++) begin
      code = field[(k-1)*CW +: CW];
      dup  = 1'b0;
      for (int j = 1; j < k; j++) begin
        other = field[(j-1)*CW +: CW];
        if (other == code) dup = 1'b1;
      end
      hit = 1'b0;
      for (int p = 0; p < NPER; p++)
        if (code == CW'(p) && eff_pend[p]) hit = 1'b1;
      lvl_code[k] = code;
      lvl_req[k]  = hit && !dup;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      ext_q  <= 1'b0;
    end else begin
      pend_q <= eff_pend & ~clr_per;
      ext_q  <= eff_ext & ~clr_ext;
    end
  end

  generate
    for (genvar p = 0; p < NPER; p++) begin : g_pend_chk
      assert_pend_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (per_req[p] && !clr_per[p]) |=> pend_q[p]);
    end
    for (genvar k = 1; k <= NSLOT; k++) begin : g_slot_chk
      assert_unused_silent_R10: assert property (@(posedge clk) disable iff (rst)
        lvl_req[k] |-> (int'(lvl_code[k]) < NPER));
      for (genvar j = 1; j < k; j++) begin : g_pair
        assert_dup_single_R9: assert property (@(posedge clk) disable iff (rst)
          (lvl_req[k] && lvl_req[j]) |-> (lvl_code[k] != lvl_code[j]));
      end
    end
  endgenerate
endmodule

// File: rtl/intc_nest_ctrl.sv
module intc_nest_ctrl #(
  parameter int CW    = 3,
  parameter int NSLOT = 5,
  parameter int NPER  = 5,
  parameter int LW    = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSLOT:0]          lvl_req,
  input  logic [NSLOT:0][CW-1:0]  lvl_code,
  input  logic                    reti_i,
  output logic                    clr_ext,
  output logic [NPER-1:0]         clr_per,
  output logic                    take_o,
  output logic [LW-1:0]           take_lvl_o,
  output logic [CW-1:0]           take_code_o,
  output logic [LW-1:0]           cur_lvl_o
);
  localparam logic [LW-1:0] MAIN_LVL = LW'(NSLOT + 1);

  logic [NSLOT:0]  isr_q, isr_d, win_oh;
  logic [LW-1:0]   win, cur_d;
  logic [CW-1:0]   win_code;
  logic            grant;

  always_comb begin
    win      = MAIN_LVL;
    win_code = '0;
    for (int i = NSLOT; i >= 0; i--) begin
      if (lvl_req[i]) begin
        win      = LW'(i);
        win_code = lvl_code[i];
      end
    end
    grant  = !reti_i && (|lvl_req) && (win < cur_lvl_o);
    win_oh = '0;
    for (int i = 0; i <= NSLOT; i++)
      if (win == LW'(i)) win_oh[i] = 1'b1;
    if (reti_i)     isr_d = isr_q & (isr_q - 1'b1);
    else if (grant) isr_d = isr_q | win_oh;
    else            isr_d = isr_q;
    cur_d = MAIN_LVL;
    for (int i = NSLOT; i >= 0; i--)
      if (isr_d[i]) cur_d = LW'(i);
    clr_ext = grant && (win == '0);
    for (int p = 0; p < NPER; p++)
      clr_per[p] = grant && (win != '0) && (win_code == CW'(p));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q       <= '0;
      cur_lvl_o   <= MAIN_LVL;
      take_o      <= 1'b0;
      take_lvl_o  <= '0;
      take_code_o <= '0;
    end else begin
      isr_q     <= isr_d;
      cur_lvl_o <= cur_d;
      take_o    <= grant;
      if (grant) begin
        take_lvl_o  <= win;
        take_code_o <= win_code;
      end
    end
  end

  assert_take_preempts_R5: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (take_lvl_o < $past(cur_lvl_o)));
  assert_take_current_R5: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (cur_lvl_o == take_lvl_o));
  assert_no_take_on_reti_R7: assert property (@(posedge clk) disable iff (rst)
    reti_i |=> !take_o);
  assert_reti_unwinds_R7: assert property (@(posedge clk) disable iff (rst)
    reti_i |=> (cur_lvl_o >= $past(cur_lvl_o)));
  assert_level_moves_R6: assert property (@(posedge clk) disable iff (rst)
    (!reti_i && !grant) |=> $stable(cur_lvl_o));
  assert_idle_reti_R12: assert property (@(posedge clk) disable iff (rst)
    (reti_i && cur_lvl_o == MAIN_LVL) |=> (cur_lvl_o == MAIN_LVL));
  assert_one_clear_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clr_ext, clr_per}));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int CW    = CODE_W,
  parameter int NSLOT = NUM_SLOT,
  parameter int NPER  = NUM_PER,
  parameter int LW    = LVL_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [7:0]      cfg_wdata,
  input  logic            ext_req,
  input  logic [NPER-1:0] per_req,
  input  logic            reti,
  output logic [LW-1:0]   cur_level,
  output logic            take,
  output logic [LW-1:0]   take_level,
  output logic [CW-1:0]   take_code
);
  localparam int FW = NSLOT * CW;

  logic [FW-1:0]               field;
  logic [NSLOT:0]              lvl_req;
  logic [NSLOT:0][CW-1:0]      lvl_code;
  logic                        clr_ext;
  logic [NPER-1:0]             clr_per;

  intc_cfg_regs #(.CW(CW), .NSLOT(NSLOT)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .field(field)
  );

  intc_req_map #(.CW(CW), .NSLOT(NSLOT), .NPER(NPER)) u_map (
    .clk(clk), .rst(rst), .ext_req(ext_req), .per_req(per_req),
    .field(field), .clr_ext(clr_ext), .clr_per(clr_per),
    .lvl_req(lvl_req), .lvl_code(lvl_code)
  );

  intc_nest_ctrl #(.CW(CW), .NSLOT(NSLOT), .NPER(NPER), .LW(LW)) u_nest (
    .clk(clk), .rst(rst), .lvl_req(lvl_req), .lvl_code(lvl_code),
    .reti_i(reti), .clr_ext(clr_ext), .clr_per(clr_per),
    .take_o(take), .take_lvl_o(take_level), .take_code_o(take_code),
    .cur_lvl_o(cur_level)
  );
endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       ext_req = 1'b0;
  logic [4:0] per_req = '0;
  logic       reti = 1'b0;
  logic [2:0] cur_level, take_level, take_code;
  logic       take;

  int n_chk = 0, n_fail = 0;

  // reference state
  logic [14:0] m_cfg;
  logic [4:0]  m_pend;
  logic        m_ext;
  logic [5:0]  m_isr;

  prio_intc u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ext_req(ext_req), .per_req(per_req),
    .reti(reti), .cur_level(cur_level), .take(take),
    .take_level(take_level), .take_code(take_code)
  );

  always #5 clk = ~clk;

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int cur_of(input logic [5:0] isr);
    for (int i = 0; i < 6; i++) if (isr[i]) return i;
    return 6;
  endfunction

  // One cycle: drive at negedge, pass posedge, compare at next negedge.
  task automatic step(input bit e, input logic [4:0] p, input bit r,
                      input bit we, input bit sel, input logic [7:0] d,
                      input string tag);
    logic [4:0] ep; logic ee; logic [5:0] rq; logic [2:0] cd [6];
    int win, cur; bit g; logic [5:0] nisr; logic [4:0] np; logic ne;
    ext_req = e; per_req = p; reti = r; cfg_we = we; cfg_sel = sel; cfg_wdata = d;
    ep = m_pend | p; ee = m_ext | e; rq = '0;
    rq[0] = ee; cd[0] = 3'b111;
    for (int k = 1; k <= 5; k++) begin
      bit dup; cd[k] = m_cfg[(k-1)*3 +: 3]; dup = 0;
      for (int j = 1; j < k; j++) if (m_cfg[(j-1)*3 +: 3] == cd[k]) dup = 1;
      rq[k] = !dup && (cd[k] < 5) && ep[cd[k]];   // R9 R10
    end
    win = 6;
    for (int i = 5; i >= 0; i--) if (rq[i]) win = i;   // R11
    cur = cur_of(m_isr);
    g = !r && win < cur;                             // R5 R6
    nisr = m_isr; np = ep; ne = ee;
    if (r) begin
      for (int i = 0; i < 6; i++) if (nisr[i]) begin nisr[i] = 0; break; end // R7
    end else if (g) begin
      nisr[win] = 1;
      if (win == 0) ne = 0; else np[cd[win]] = 0;    // R8
    end
    @(negedge clk);
    check(int'(take), int'(g), {tag, " take"});
    check(int'(cur_level), cur_of(nisr), {tag, " cur_level"});
    if (g) begin
      check(int'(take_level), win, {tag, " take_level"});
      check(int'(take_code), int'(cd[win]), {tag, " take_code"});
    end
    m_isr = nisr; m_pend = np; m_ext = ne;
    if (we) begin                                    // R2
      if (sel) m_cfg[14:8] = d[6:0];
      else     m_cfg[7:0]  = d;
    end
    ext_req = 0; per_req = '0; reti = 0; cfg_we = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, '0, tag);
  endtask

  task automatic wr(input bit sel, input logic [7:0] d, input string tag);
    step(0, '0, 0, 1, sel, d, tag);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_cfg = 15'h4688; m_pend = '0; m_ext = 0; m_isr = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(int'(cur_level), 6, "R1 reset cur_level");
    check(int'(take), 0, "R1 reset take");
    // R1 R4 default mapping: code 3 at level 4
    step(0, 5'b01000, 0, 0, 0, '0, "R1 default map");
    check(int'(take_level), 4, "R1 default level of code 3");
    check(int'(take_code), 3, "R4 code of timer2");
    step(0, '0, 1, 0, 0, '0, "R7 back to main");
    check(int'(cur_level), 6, "R7 cur after return");
    // R2 example programming
    wr(0, 8'hC1, "R2 low write");
    wr(1, 8'hA8, "R2 high write");
    step(0, 5'b00010, 0, 0, 0, '0, "R2 timer0");
    check(int'(take_level), 1, "R2 timer0 at level 1");
    step(0, '0, 1, 0, 0, '0, "R7 return");
    // R5 nesting: UART(L4), ADC(L2) preempts, timer1(L5) waits
    step(0, 5'b10000, 0, 0, 0, '0, "R5 uart");
    check(int'(cur_level), 4, "R5 uart level");
    step(0, 5'b00001, 0, 0, 0, '0, "R5 adc preempts");
    check(int'(take_level), 2, "R5 adc level");
    step(0, 5'b00100, 0, 0, 0, '0, "R6 timer1 waits");
    check(int'(take), 0, "R6 no take for lower level");
    idle(3, "R8 pending held");
    step(1, '0, 0, 0, 0, '0, "R3 external");
    check(int'(take_code), 7, "R3 external code");
    check(int'(take_level), 0, "R3 external level");
    step(0, '0, 1, 0, 0, '0, "R7 return to 2");
    check(int'(cur_level), 2, "R7 restored level 2");
    step(0, '0, 1, 0, 0, '0, "R7 return to 4");
    check(int'(cur_level), 4, "R7 restored level 4");
    step(0, '0, 1, 0, 0, '0, "R7 return to main");
    check(int'(take), 0, "R7 no take on return edge");
    step(0, '0, 0, 0, 0, '0, "R8 timer1 fires");
    check(int'(take_level), 5, "R8 pending timer1 level 5");
    step(0, '0, 1, 0, 0, '0, "R7 return");
    // R12 return with nothing in service
    step(0, '0, 1, 0, 0, '0, "R12 idle return");
    check(int'(cur_level), 6, "R12 cur stays 6");
    // R9 duplicate code 2 in levels 1 and 2
    wr(0, 8'h12, "R9 low");
    wr(1, 8'h00, "R9 high");
    step(0, 5'b00100, 0, 0, 0, '0, "R9 dup");
    check(int'(take_level), 1, "R9 lower slot wins");
    step(0, '0, 1, 0, 0, '0, "R9 return");
    idle(2, "R9 no second fire");
    // R10 all unused
    wr(0, 8'hFF, "R10 low");
    wr(1, 8'hFF, "R10 high");
    step(0, 5'b11111, 0, 0, 0, '0, "R10 unused");
    check(int'(take), 0, "R10 no take");
    idle(2, "R10 quiet");
    // R11 simultaneous with default map
    wr(0, 8'h88, "R11 low");
    wr(1, 8'h46, "R11 high");
    step(1, 5'b11000, 0, 0, 0, '0, "R11 simultaneous");
    check(int'(take_level), 0, "R11 external wins");
    for (int i = 0; i < 12; i++) step(0, '0, 1, 0, 0, '0, "R7 drain");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] p; bit e, r, we;
      p = '0;
      for (int b = 0; b < 5; b++) p[b] = ($urandom % 8) == 0;
      e  = ($urandom % 20) == 0;
      r  = ($urandom % 5) == 0;
      we = ($urandom % 40) == 0;
      step(e, p, r, we, 1'($urandom), 8'($urandom), "R5 random");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule